// File: doc/BRIEF.md
# Cache Enable and Invalidate-Sweep Controller

This block owns the on/off control of a single cache, instruction or data. Software writes one enable bit. When that bit goes from 1 to 0, the block does not stop the cache on the spot. It first sweeps the valid-bit array, one line index per cycle, and clears each valid bit through a clear port made of an index and a strobe. Only after the last line has been cleared does it stop the cache. The lookup logic sees this through a cache-active signal, and the hit, refill and cache-write requests passing through the block are masked whenever that signal is low.

A readable status bit stays at 1 while the cache is running and throughout any sweep that a disable starts. It falls to 0 once the sweep has finished. Software polls this bit until it reads 0 before it sets the enable bit again, so the cache always restarts with every line invalid. The block also runs the same sweep once when it leaves reset, so the valid array never holds stale state. Tag comparison, refill and data storage are handled by other blocks.

The controller has four states:
- `ST_SWEEP_INIT` is the sweep after reset.
- `ST_STOPPED` means the cache is idle.
- `ST_RUNNING` means the cache is operating.
- `ST_SWEEP_FLUSH` is the sweep started by a disable.

The transitions are:
- reset → `ST_SWEEP_INIT`
- `ST_SWEEP_INIT` → `ST_STOPPED` on the last index
- `ST_STOPPED` → `ST_RUNNING` when the stored enable is 1
- `ST_RUNNING` → `ST_SWEEP_FLUSH` when the stored enable is 0
- `ST_SWEEP_FLUSH` → `ST_STOPPED` on the last index

Top module: `cache_flush_seq`

## Requirements
- R1: After reset, `cfg_en`, `stat_busy` and `cache_active` are 0. A sweep starts at once: `vclr_stb` is 1 with `vclr_idx` = 0 in the first cycle after reset is released.
- R2: A write (`cfg_wr` = 1) stores `cfg_wdata`, and `cfg_en` shows the stored value from the next cycle on.
- R3: In the stopped state, a stored enable of 1 moves the block to running one cycle after `cfg_en` rises. At that point `cache_active` and `stat_busy` are both 1.
- R4: In the running state, a stored enable of 0 starts a sweep on the next cycle. `vclr_stb` is then 1 for exactly NUM_LINES consecutive cycles, and `vclr_idx` counts up from 0 to NUM_LINES-1, one step per cycle.
- R5: `stat_busy` stays at 1 throughout a disable-started sweep. It becomes 0 in the cycle after the last index is cleared.
- R6: `cache_active` is 1 only in the running state. Whenever it is 0, every `lk_hit` bit is 0; when it is 1, `lk_hit` equals `lk_hit_raw`.
- R7: `fill_go` and `wr_go` equal `fill_req` and `wr_req` when `cache_active` is 1, and are 0 otherwise.
- R8: Setting the enable again during a disable-started sweep does not shorten the sweep. The block then spends one cycle stopped, with `stat_busy` at 0, and enters running in the cycle after that.
- R9: Setting the enable during the power-on sweep takes effect only after that sweep has cleared the last index.
- R10: Writing 1 while running, or writing 0 while stopped, changes neither `cache_active` nor `stat_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the enable bit |
| cfg_wdata | input | 1 | Value to store in the enable bit |
| cfg_en | output | 1 | Stored enable bit, read back |
| stat_busy | output | 1 | 1 while running or sweeping after a disable |
| cache_active | output | 1 | Cache operating; lookup logic may hit, refill or write |
| vclr_idx | output | IDX_W | Line index to invalidate |
| vclr_stb | output | 1 | Clear strobe for the valid bit at `vclr_idx` |
| lk_hit_raw | input | LANES | Raw hit from each tag comparator lane |
| lk_hit | output | LANES | Hit after masking by the cache state |
| fill_req | input | LANES | Refill request from each lane |
| fill_go | output | LANES | Refill permitted |
| wr_req | input | LANES | Cache-write request from each lane |
| wr_go | output | LANES | Cache write permitted |

## Verification
The bench goes after several corner cases of the sweep and the enable bit:
- **Sweep length.** A design that stopped the sweep early, or re-entered running on a late enable, would leave lines valid. The bench sees this as fewer than NUM_LINES strobes, or as `cache_active` rising before the last index.
- **Status timing.** Dropping `stat_busy` when the disable is written, rather than when the sweep ends, shows up as a status mismatch during the sweep.
- **Redundant writes.** A design that restarted the sweep on a second write of 0, or on a write of 1 while running, would show a strobe or a status change where the model expects none.
- **Masking.** Random hit, fill and write patterns are driven in every state, so any lane that leaks a hit or a request while the cache is inactive is caught.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        ST_SWEEP_INIT  = 2'd0,
        ST_STOPPED     = 2'd1,
        ST_RUNNING     = 2'd2,
        ST_SWEEP_FLUSH = 2'd3
    } cfs_state_e;

endpackage

// File: rtl/cfs_enable_reg.sv
module cfs_enable_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wdata,
    output logic en_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (wr) begin
            en_q <= wdata;
        end
    end

endmodule

// File: rtl/cfs_index_walker.sv
module cfs_index_walker #(
    parameter int NUM_LINES = 64,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    logic [IDX_W-1:0] cnt_q;

    assign at_last = (cnt_q == LAST_IDX);
    assign idx     = cnt_q;

    // Counter wraps to zero after the last line, so every sweep starts at 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            if (at_last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfs_fsm.sv
module cfs_fsm
    import cfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_q,
    input  logic at_last,
    output logic walking,
    output logic running,
    output logic busy
);

    cfs_state_e state_q;
    cfs_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SWEEP_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SWEEP_INIT:  if (at_last) state_d = ST_STOPPED;
            ST_STOPPED:     if (en_q)    state_d = ST_RUNNING;
            ST_RUNNING:     if (!en_q)   state_d = ST_SWEEP_FLUSH;
            ST_SWEEP_FLUSH: if (at_last) state_d = ST_STOPPED;
            default:                     state_d = ST_STOPPED;
        endcase
    end

    always_comb begin
        walking = 1'b0;
        running = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            ST_SWEEP_INIT:  walking = 1'b1;
            ST_STOPPED:     ;
            ST_RUNNING:     begin running = 1'b1; busy = 1'b1; end
            ST_SWEEP_FLUSH: begin walking = 1'b1; busy = 1'b1; end
            default:        ;
        endcase
    end

endmodule

// File: rtl/cfs_lookup_gate.sv
module cfs_lookup_gate #(
    parameter int LANES = 2
) (
    input  logic             active,
    input  logic [LANES-1:0] hit_raw,
    input  logic [LANES-1:0] fill_req,
    input  logic [LANES-1:0] wr_req,
    output logic [LANES-1:0] hit,
    output logic [LANES-1:0] fill_go,
    output logic [LANES-1:0] wr_go
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit[g]     = hit_raw[g]  & active;
        assign fill_go[g] = fill_req[g] & active;
        assign wr_go[g]   = wr_req[g]   & active;
    end

endmodule

// File: rtl/cache_flush_seq.sv
module cache_flush_seq #(
    parameter int NUM_LINES = 64,
    parameter int LANES     = 2,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_wdata,
    output logic             cfg_en,
    output logic             stat_busy,
    output logic             cache_active,
    output logic [IDX_W-1:0] vclr_idx,
    output logic             vclr_stb,
    input  logic [LANES-1:0] lk_hit_raw,
    output logic [LANES-1:0] lk_hit,
    input  logic [LANES-1:0] fill_req,
    output logic [LANES-1:0] fill_go,
    input  logic [LANES-1:0] wr_req,
    output logic [LANES-1:0] wr_go
);

    logic en_q;
    logic at_last;
    logic walking;
    logic running;
    logic busy;

    cfs_enable_reg u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .en_q  (en_q)
    );

    cfs_index_walker #(.NUM_LINES(NUM_LINES)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (walking),
        .idx     (vclr_idx),
        .at_last (at_last)
    );

    cfs_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_q    (en_q),
        .at_last (at_last),
        .walking (walking),
        .running (running),
        .busy    (busy)
    );

    cfs_lookup_gate #(.LANES(LANES)) u_gate (
        .active   (running),
        .hit_raw  (lk_hit_raw),
        .fill_req (fill_req),
        .wr_req   (wr_req),
        .hit      (lk_hit),
        .fill_go  (fill_go),
        .wr_go    (wr_go)
    );

    assign cfg_en       = en_q;
    assign stat_busy    = busy;
    assign cache_active = running;
    assign vclr_stb     = walking;

endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
    parameter int NUM_LINES = 64,
    parameter int LANES     = 2,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             stat_busy,
    input logic             cache_active,
    input logic [IDX_W-1:0] vclr_idx,
    input logic             vclr_stb,
    input logic [LANES-1:0] lk_hit,
    input logic [LANES-1:0] fill_go,
    input logic [LANES-1:0] wr_go
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    p_stb_not_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vclr_stb |-> !cache_active);

    p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vclr_stb && vclr_idx != '0) |->
            ($past(vclr_stb) && vclr_idx == IDX_W'($past(vclr_idx) + 1'b1)));

    p_status_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_busy) |-> ($past(vclr_stb) && $past(vclr_idx) == LAST_IDX));

    p_active_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cache_active |-> stat_busy);

    p_hit_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_active |-> (lk_hit == '0));

    p_req_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_active |-> (fill_go == '0 && wr_go == '0));

    p_run_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cache_active) |-> cfg_en);

    p_sweep_ends_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vclr_stb) |-> (!cache_active && !stat_busy));

endmodule

bind cache_flush_seq cfs_checker #(.NUM_LINES(NUM_LINES), .LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_en       (cfg_en),
    .stat_busy    (stat_busy),
    .cache_active (cache_active),
    .vclr_idx     (vclr_idx),
    .vclr_stb     (vclr_stb),
    .lk_hit       (lk_hit),
    .fill_go      (fill_go),
    .wr_go        (wr_go)
);

// File: tb/sim_cache_flush_seq.sv
module sim_cache_flush_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 64;
    localparam int LN         = 2;
    localparam int IW         = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic          cfg_wdata = 1'b0;
    logic          cfg_en;
    logic          stat_busy;
    logic          cache_active;
    logic [IW-1:0] vclr_idx;
    logic          vclr_stb;
    logic [LN-1:0] lk_hit_raw = '0;
    logic [LN-1:0] lk_hit;
    logic [LN-1:0] fill_req = '0;
    logic [LN-1:0] fill_go;
    logic [LN-1:0] wr_req = '0;
    logic [LN-1:0] wr_go;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    stb_run = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // Reference model: phase 0 power-on sweep, 1 stopped, 2 running, 3 disable sweep
    int m_ph = 0;
    int m_cnt = 0;
    bit m_en = 1'b0;
    bit m_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_flush_seq #(.NUM_LINES(NL), .LANES(LN)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_en(cfg_en), .stat_busy(stat_busy), .cache_active(cache_active),
        .vclr_idx(vclr_idx), .vclr_stb(vclr_stb), .lk_hit_raw(lk_hit_raw),
        .lk_hit(lk_hit), .fill_req(fill_req), .fill_go(fill_go),
        .wr_req(wr_req), .wr_go(wr_go)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 1'b0; m_ph = 0; m_cnt = 0;
        end else begin
            case (m_ph)
                0, 3: if (m_cnt == NL - 1) begin m_ph = 1; m_cnt = 0; end
                      else m_cnt = m_cnt + 1;
                1: if (m_en) m_ph = 2;
                2: if (!m_en) m_ph = 3;
                default: ;
            endcase
            if (cfg_wr) m_en = cfg_wdata;
        end
        m_seen = 1'b1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) cycle %0d: actual %0d expected %0d", tag, cur_tag, cyc, act, exp);
        end
    endtask

    always begin
        @(negedge clk);
        #3;
        cyc++;
        if (m_seen && !done) begin
            automatic bit act_exp = (m_ph == 2);
            automatic bit stb_exp = (m_ph == 0 || m_ph == 3);
            chk("R2 cfg_en", int'(cfg_en), int'(m_en));
            chk("R5 stat_busy", int'(stat_busy), int'(m_ph == 2 || m_ph == 3));
            chk("R3 cache_active", int'(cache_active), int'(act_exp));
            chk("R4 vclr_stb", int'(vclr_stb), int'(stb_exp));
            if (stb_exp) chk("R4 vclr_idx", int'(vclr_idx), m_cnt);
            chk("R6 lk_hit", int'(lk_hit), act_exp ? int'(lk_hit_raw) : 0);
            chk("R7 fill_go", int'(fill_go), act_exp ? int'(fill_req) : 0);
            chk("R7 wr_go", int'(wr_go), act_exp ? int'(wr_req) : 0);
            if (vclr_stb) stb_run++;
        end
    end

    // Random lane traffic in every state
    always @(negedge clk) begin
        lk_hit_raw <= LN'($urandom);
        fill_req   <= LN'($urandom);
        wr_req     <= LN'($urandom);
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_en(input bit v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            finish_run();
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        #3;
        // R1: reset values and power-on sweep starting at index 0
        chk("R1 en after reset", int'(cfg_en), 0);
        chk("R1 busy after reset", int'(stat_busy), 0);
        chk("R1 sweep idx0", int'(vclr_stb && vclr_idx == '0), 1);
        // R9: enable written during the power-on sweep
        cur_tag = "R9";
        wait_cyc(10);
        write_en(1'b1);
        wait_cyc(NL);
        chk("R9 running after init sweep", int'(cache_active), 1);
        // R10: redundant write of 1 while running
        cur_tag = "R10";
        write_en(1'b1);
        wait_cyc(4);
        chk("R10 still running", int'(cache_active), 1);
        // R4/R5: disable starts a full sweep
        cur_tag = "R4";
        stb_run = 0;
        write_en(1'b0);
        wait_cyc(NL + 6);
        chk("R4 sweep length", stb_run, NL);
        chk("R5 busy low after sweep", int'(stat_busy), 0);
        // R10: redundant write of 0 while stopped
        cur_tag = "R10";
        stb_run = 0;
        write_en(1'b0);
        wait_cyc(3);
        chk("R10 no sweep on idle disable", stb_run, 0);
        // R3: enable from stopped
        cur_tag = "R3";
        write_en(1'b1);
        wait_cyc(3);
        // R8: re-enable in mid-sweep
        cur_tag = "R8";
        stb_run = 0;
        write_en(1'b0);
        wait_cyc(20);
        write_en(1'b1);
        wait_cyc(NL);
        chk("R8 sweep not cut short", stb_run, NL);
        chk("R8 running after sweep", int'(cache_active), 1);
        // Toggle inside a sweep ending disabled
        cur_tag = "R8";
        write_en(1'b0);
        wait_cyc(2);
        write_en(1'b1);
        write_en(1'b0);
        wait_cyc(NL + 4);
        chk("R8 stopped when last write is 0", int'(stat_busy), 0);
        finish_run();
    end

endmodule